// File: doc/BRIEF.md
# Multi-mode quadrature position counter

This block keeps a 32-bit position count driven by two encoder inputs, A and B. A two-bit source field picks one of four counting schemes at run time. The schemes are full x4 quadrature decoding, pulse with direction, count up on A only, and count down on A only. In the two single-input schemes an option makes both edges of A count instead of only its rising edge. Both encoder inputs pass through a two-flop synchronizer. Edges are then found by comparing each synchronized sample with the one registered a cycle earlier.

Software reaches the block through a simple synchronous register port. Through it software can read the count, load the count, program a ceiling, pick the source and edge option, and turn counting on or off. The count runs from 0 to the ceiling and wraps at both ends. A load above the ceiling is refused. In quadrature mode, a sample in which both inputs change at once is illegal. Such a sample produces no count and sets a sticky error output.

Top module: `qpc_top`

## Requirements
- R1: After reset the count reads 0, the ceiling (byte address 0x08) reads 0xFFFFFFFF, the decoder control (0x28) and main control (0x2A) read 0, and quad_err is 0. An address with no register, for example 0x04, reads 0.
- R2: With source 00 (decoder control bits 15:14), the input pair {A,B} stepping 00→01→11→10→00 adds one to the count on each step, so every edge of either input counts.
- R3: With source 00, the reverse order 00→10→11→01→00 subtracts one on each step.
- R4: With source 00, a sample in which A and B both change leaves the count unchanged and sets quad_err. quad_err then stays 1 until reset.
- R5: With source 01, each rising edge of A adds one when B is high and subtracts one when B is low. Falling edges of A and all edges of B leave the count unchanged.
- R6: With source 10 and decoder control bit 11 clear, each rising edge of A adds one. Falling edges of A and all edges of B leave the count unchanged.
- R7: With source 11 and bit 11 clear, each rising edge of A subtracts one, and a falling edge of A has no effect.
- R8: With source 10 or 11 and bit 11 set, both the rising and the falling edge of A count, adding one (source 10) or subtracting one (source 11).
- R9: Bit 3 of the main control register (0x2A) enables counting. While it is clear, encoder activity leaves the count unchanged.
- R10: A write to the count (0x00) with a value no greater than the ceiling loads that value. A write with a value above the ceiling is refused and the count keeps its value.
- R11: Counting up from a count at or above the ceiling gives 0. Counting down from 0 gives the ceiling.
- R12: Changing the source field leaves the current count unchanged.
- R13: An input change alters the count at the third rising clock edge after it is applied and not earlier. A register write is visible in the read data after the edge that takes it. Read data is a combinational function of reg_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder input A (asynchronous) |
| enc_b | input | 1 | Encoder input B (asynchronous) |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| quad_err | output | 1 | Sticky illegal-transition flag |

## Verification
An encoder change passes through two synchronizer flops and then changes the count register, so its effect is due at the third rising edge after the change. The latency test reads the count after the second edge, where the old value is expected, and again after the third edge, where the new value is expected. Every other encoder step waits four rising edges before the count is read, so each check falls after the expected update. Register writes take effect at the following edge. Reads sample the combinational read data in the middle of the low clock phase, one cycle after the write strobe drops.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    localparam logic [7:0] ADDR_COUNT = 8'h00;
    localparam logic [7:0] ADDR_CEIL  = 8'h08;
    localparam logic [7:0] ADDR_DEC   = 8'h28;
    localparam logic [7:0] ADDR_CTL   = 8'h2A;

    localparam int SRC_HI   = 15;
    localparam int SRC_LO   = 14;
    localparam int BOTH_BIT = 11;
    localparam int EN_BIT   = 3;

    typedef enum logic [1:0] {
        SRC_QUAD = 2'b00,
        SRC_DIR  = 2'b01,
        SRC_UP   = 2'b10,
        SRC_DOWN = 2'b11
    } src_e;

    typedef struct packed {
        src_e src;
        logic both;
    } dec_cfg_t;

    typedef struct packed {
        logic inc;
        logic dec;
        logic bad;
    } step_t;

    // Gray state {A,B} to a position 0..3 along the counting-up order.
    function automatic logic [1:0] gray_pos(input logic [1:0] ab);
        return {ab[1], ab[1] ^ ab[0]};
    endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ab,
    input  dec_cfg_t   cfg,
    output step_t      step
);
    logic [1:0] ab_prev;
    logic [1:0] diff;
    logic       a_rise;
    logic       a_fall;
    logic       a_edge;

    always_ff @(posedge clk) begin
        if (rst) ab_prev <= '0;
        else     ab_prev <= ab;
    end

    assign a_rise = ab[1] & ~ab_prev[1];
    assign a_fall = ~ab[1] & ab_prev[1];
    assign a_edge = a_rise | (cfg.both & a_fall);
    assign diff   = gray_pos(ab) - gray_pos(ab_prev);

    always_comb begin
        step = '0;
        unique case (cfg.src)
            SRC_QUAD: begin
                step.inc = (diff == 2'd1);
                step.dec = (diff == 2'd3);
                step.bad = (diff == 2'd2);
            end
            SRC_DIR: begin
                step.inc = a_rise & ab[0];
                step.dec = a_rise & ~ab[0];
            end
            SRC_UP:   step.inc = a_edge;
            SRC_DOWN: step.dec = a_edge;
            default:  step = '0;
        endcase
    end
endmodule

// File: rtl/qpc_count.sv
module qpc_count
    import qpc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  step_t        step,
    input  logic         wr_cnt,
    input  logic         wr_ceil,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] ceil
);
    logic accept;

    assign accept = wr_cnt && (wdata <= ceil);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (accept) begin
            cnt <= wdata;
        end else if (en && step.inc) begin
            cnt <= (cnt >= ceil) ? '0 : cnt + 1'b1;
        end else if (en && step.dec) begin
            cnt <= (cnt == '0) ? ceil : cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ceil <= '1;
        else if (wr_ceil) ceil <= wdata;
    end
endmodule

// File: rtl/qpc_top.sv
module qpc_top
    import qpc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              quad_err
);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(ADDR_COUNT);
    localparam logic [ADDR_W-1:0] A_CEIL  = ADDR_W'(ADDR_CEIL);
    localparam logic [ADDR_W-1:0] A_DEC   = ADDR_W'(ADDR_DEC);
    localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(ADDR_CTL);

    logic [1:0]       ab_sync;
    dec_cfg_t         cfg_q;
    logic             en_q;
    logic             err_q;
    step_t            step;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ceil_q;
    logic             wr_dec;
    logic             wr_ctl;

    assign wr_dec = reg_wr && (reg_addr == A_DEC);
    assign wr_ctl = reg_wr && (reg_addr == A_CTL);

    qpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({enc_a, enc_b}),
        .q   (ab_sync)
    );

    qpc_decode u_dec (
        .clk  (clk),
        .rst  (rst),
        .ab   (ab_sync),
        .cfg  (cfg_q),
        .step (step)
    );

    qpc_count #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .step    (step),
        .wr_cnt  (reg_wr && (reg_addr == A_COUNT)),
        .wr_ceil (reg_wr && (reg_addr == A_CEIL)),
        .wdata   (reg_wdata),
        .cnt     (cnt_q),
        .ceil    (ceil_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{src: SRC_QUAD, both: 1'b0};
        end else if (wr_dec) begin
            cfg_q.src  <= src_e'(reg_wdata[SRC_HI:SRC_LO]);
            cfg_q.both <= reg_wdata[BOTH_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         en_q <= 1'b0;
        else if (wr_ctl) en_q <= reg_wdata[EN_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q | step.bad;
    end

    assign quad_err = err_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_COUNT: reg_rdata = cnt_q;
            A_CEIL:  reg_rdata = ceil_q;
            A_DEC: begin
                reg_rdata[SRC_HI:SRC_LO] = cfg_q.src;
                reg_rdata[BOTH_BIT]      = cfg_q.both;
            end
            A_CTL:   reg_rdata[EN_BIT] = en_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker
    import qpc_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        ab_sync,
    input logic [1:0]        src,
    input logic              en,
    input logic              inc,
    input logic              dec,
    input logic              bad,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic [W-1:0]      cnt,
    input logic [W-1:0]      ceil,
    input logic              quad_err
);
    logic wr_cnt;
    logic single_src;
    assign wr_cnt     = reg_wr && (reg_addr == ADDR_W'(ADDR_COUNT));
    assign single_src = (src == SRC_UP) || (src == SRC_DOWN);

    AST_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
        !(inc && dec)); // R2

    AST_BAD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        bad |-> (!inc && !dec)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        quad_err |=> quad_err); // R4

    AST_B_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (single_src && (ab_sync[1] == $past(ab_sync[1]))) |-> (!inc && !dec)); // R6

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_cnt) |=> $stable(cnt)); // R9

    AST_REJECT_BIG: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt && (reg_wdata > ceil) && !(en && (inc || dec))) |=> $stable(cnt)); // R10

    AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (en && inc && !reg_wr && (cnt >= ceil)) |=> (cnt == '0)); // R11

    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (en && dec && !reg_wr && (cnt == '0)) |=> (cnt == $past(ceil))); // R11
endmodule

bind qpc_top qpc_checker #(.W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ab_sync   (ab_sync),
    .src       (cfg_q.src),
    .en        (en_q),
    .inc       (step.inc),
    .dec       (step.dec),
    .bad       (step.bad),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt       (cnt_q),
    .ceil      (ceil_q),
    .quad_err  (quad_err)
);

// File: tb/sim_qpc_top.sv
`timescale 1ns/1ps
module sim_qpc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 1'b0;
    logic        enc_b = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        quad_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    qpc_top u0 (
        .clk       (clk),
        .rst       (rst),
        .enc_a     (enc_a),
        .enc_b     (enc_b),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .quad_err  (quad_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_addr  = addr;
        reg_wdata = data;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] addr, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = addr;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic set_ab(input logic a, input logic b);
        @(negedge clk);
        enc_a = a;
        enc_b = b;
        repeat (4) @(posedge clk);
    endtask

    task automatic step_chk(input string tag, input logic a, input logic b, input logic [31:0] exp);
        set_ab(a, b);
        rd_chk(tag, 8'h00, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 count", 8'h00, 32'h0);
        rd_chk("R1 ceiling", 8'h08, 32'hFFFF_FFFF);
        rd_chk("R1 decctl", 8'h28, 32'h0);
        rd_chk("R1 mainctl", 8'h2A, 32'h0);
        rd_chk("R1 unused", 8'h04, 32'h0);
        chk("R1 err", {31'b0, quad_err}, 32'h0);
    endtask

    task automatic t_disabled;
        step_chk("R9 off a", 1, 0, 32'd0);
        step_chk("R9 off b", 0, 0, 32'd0);
        wr(8'h2A, 32'h8);
        rd_chk("R9 enable readback", 8'h2A, 32'h8);
    endtask

    task automatic t_latency;
        @(negedge clk);
        enc_b = 1'b1;
        repeat (2) @(posedge clk);
        rd_chk("R13 not yet", 8'h00, 32'd0);
        @(posedge clk);
        rd_chk("R13 third edge", 8'h00, 32'd1);
    endtask

    task automatic t_quad_up;
        step_chk("R2 step 11", 1, 1, 32'd2);
        step_chk("R2 step 10", 1, 0, 32'd3);
        step_chk("R2 step 00", 0, 0, 32'd4);
    endtask

    task automatic t_quad_down;
        step_chk("R3 step 10", 1, 0, 32'd3);
        step_chk("R3 step 11", 1, 1, 32'd2);
        step_chk("R3 step 01", 0, 1, 32'd1);
        step_chk("R3 step 00", 0, 0, 32'd0);
    endtask

    task automatic t_wrap;
        wr(8'h08, 32'd9);
        rd_chk("R13 ceiling write", 8'h08, 32'd9);
        step_chk("R11 down wrap", 1, 0, 32'd9);
        step_chk("R11 up wrap", 0, 0, 32'd0);
    endtask

    task automatic t_illegal;
        step_chk("R4 both change", 1, 1, 32'd0);
        chk("R4 err set", {31'b0, quad_err}, 32'h1);
        step_chk("R4 legal after", 1, 0, 32'd1);
        step_chk("R4 legal after 2", 0, 0, 32'd2);
        chk("R4 err sticky", {31'b0, quad_err}, 32'h1);
    endtask

    task automatic t_sw_write;
        wr(8'h00, 32'd7);
        rd_chk("R10 accept", 8'h00, 32'd7);
        wr(8'h00, 32'd10);
        rd_chk("R10 reject", 8'h00, 32'd7);
        wr(8'h00, 32'd9);
        rd_chk("R10 accept at ceiling", 8'h00, 32'd9);
    endtask

    task automatic t_dir;
        wr(8'h28, 32'h4000);
        rd_chk("R12 count kept", 8'h00, 32'd9);
        rd_chk("R12 decctl readback", 8'h28, 32'h4000);
        wr(8'h00, 32'd5);
        step_chk("R5 B rise", 0, 1, 32'd5);
        step_chk("R5 A rise B high", 1, 1, 32'd6);
        step_chk("R5 A fall", 0, 1, 32'd6);
        step_chk("R5 B fall", 0, 0, 32'd6);
        step_chk("R5 A rise B low", 1, 0, 32'd5);
        step_chk("R5 A fall 2", 0, 0, 32'd5);
    endtask

    task automatic t_up;
        wr(8'h28, 32'h8000);
        step_chk("R6 A rise", 1, 0, 32'd6);
        step_chk("R6 A fall", 0, 0, 32'd6);
        step_chk("R6 B rise", 0, 1, 32'd6);
        step_chk("R6 B fall", 0, 0, 32'd6);
        wr(8'h28, 32'h8800);
        step_chk("R8 up rise", 1, 0, 32'd7);
        step_chk("R8 up fall", 0, 0, 32'd8);
    endtask

    task automatic t_down;
        wr(8'h28, 32'hC000);
        step_chk("R7 A rise", 1, 0, 32'd7);
        step_chk("R7 A fall", 0, 0, 32'd7);
        wr(8'h28, 32'hC800);
        step_chk("R8 down rise", 1, 0, 32'd6);
        step_chk("R8 down fall", 0, 0, 32'd5);
    endtask

    task automatic t_disable_again;
        wr(8'h2A, 32'h0);
        step_chk("R9 hold rise", 1, 0, 32'd5);
        step_chk("R9 hold fall", 0, 0, 32'd5);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_latency();
        t_quad_up();
        t_quad_down();
        t_wrap();
        t_illegal();
        t_sw_write();
        t_dir();
        t_up();
        t_down();
        t_disable_again();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule